// File: doc/BRIEF.md
# Locality-Aware Thread-Block Selector

This block chooses which queued thread block should be sent next to one streaming multiprocessor (SM). The aim is that blocks sharing cache lines run side by side. Each queue entry describes the data footprint of its block as a rectangle in cache-line coordinates. The rectangle has a start corner and an 8-bit width and height. The selector scores each entry against the blocks already resident on the target SM and keeps the winner in a candidate register. When a resident block completes, the held candidate is dispatched at once and a fresh selection begins.

The queue lives outside the block and is read through an index port: `q_idx` out, entry fields back in during the same cycle. The resident blocks of the target SM and of all other SMs are presented as flat coordinate vectors with valid masks, and these must stay stable while a scan runs. One scan visits one queue entry per clock. While the SM holds fewer than `INIT_RES` blocks, scoring is skipped and the head of the queue is taken directly. One instance serves one SM.

Top module: `lblk_sel`

## Requirements
- R1: A byte x coordinate (on the queue and on both resident sets) is converted to a cache-line column by integer division by `LINE_BYTES` (128). The y coordinate is used unchanged.
- R2: Distances are absolute differences of the start corners, and the candidate's width and height apply. If dx > width or dy > height, the pair contributes zero.
- R3: Otherwise a pair contributes (width − dx) × (height − dy).
- R4: An entry's total is the sum of its pair values over the resident blocks whose valid bit is high. Residents with a low valid bit add nothing. The total saturates at 65535.
- R5: When at least one entry has a nonzero total on the target SM, the entry with the largest total wins. Ties go to the lowest queue index, and `cand_score` reports that total.
- R6: When every entry totals zero on the target SM, the entry with the smallest total against the other-SM residents wins. Ties go to the lowest index, and `cand_score` is 0.
- R7: If fewer than `INIT_RES` (8) target residents are valid when a selection starts, queue index 0 is taken with score 0. `sel_done` follows on the next cycle.
- R8: A selection starts on a cycle with `sel_start` or `blk_done` high. With L ≥ 2 entries and scoring enabled, `q_idx` steps 0,1,2… one per cycle, and `sel_done` is high for one cycle, L cycles after the start cycle.
- R9: A selection started while `q_len` is 0 raises `sel_done` on the next cycle and leaves `cand_valid` low.
- R10: On `blk_done`, `disp_valid` on the next cycle equals the `cand_valid` that was held, and `disp_id` equals the held `cand_id`. The old candidate is dropped and a new selection starts.
- R11: After reset, `sel_done`, `cand_valid` and `disp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_start | input | 1 | Start a selection without dispatching |
| blk_done | input | 1 | A block on the SM completed: dispatch the candidate and reselect |
| q_len | input | QIW+1 | Number of valid queue entries |
| q_idx | output | QIW | Queue entry being read |
| q_id | input | IDW | Block ID of the addressed entry |
| q_x | input | XW | Start x of the addressed entry, in bytes |
| q_y | input | YW | Start y of the addressed entry |
| q_w | input | 8 | Width in cache lines |
| q_h | input | 8 | Height in cache lines |
| res_vld | input | NRES | Valid mask of target-SM residents |
| res_x | input | NRES*XW | Resident start x values in bytes, slot i at bits i*XW |
| res_y | input | NRES*YW | Resident start y values |
| oth_vld | input | NOTH | Valid mask of other-SM residents |
| oth_x | input | NOTH*XW | Other-SM start x values in bytes |
| oth_y | input | NOTH*YW | Other-SM start y values |
| sel_done | output | 1 | One-cycle pulse when a selection ends |
| cand_valid | output | 1 | Candidate register holds a block |
| cand_qidx | output | QIW | Queue index of the candidate |
| cand_id | output | IDW | Block ID of the candidate |
| cand_score | output | 16 | Target-SM total of the candidate |
| disp_valid | output | 1 | Dispatch pulse |
| disp_id | output | IDW | Block ID being dispatched |

## Verification
On every cycle, the assertions check the timing of the control flow: the empty-queue and bypass outcomes one cycle after a start, the one-per-cycle stepping of the scan index, and the handover of the held candidate on a completion pulse. The bench's scenarios alone show the arithmetic of the choice. These cover the line conversion, the zero cases at and beyond the rectangle edge, the product value, saturation, ignored invalid residents, ties broken toward the lower index, and the fallback to the smallest other-SM total. They also cover the exact length of each scan, checked against a reference model in the bench over directed and random queues.

// File: rtl/lblk_sel.sv
module lblk_sel #(
  parameter int NRES       = 12,
  parameter int NOTH       = 12,
  parameter int QDEPTH     = 16,
  parameter int XW         = 16,
  parameter int YW         = 12,
  parameter int IDW        = 10,
  parameter int LINE_BYTES = 128,
  parameter int INIT_RES   = 8,
  localparam int QIW = $clog2(QDEPTH),
  localparam int LSH = $clog2(LINE_BYTES),
  localparam int NMAX = (NRES > NOTH) ? NRES : NOTH,
  localparam int SW  = 16 + $clog2(NMAX + 1),
  localparam int CW  = $clog2(NRES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_start,
  input  logic               blk_done,
  input  logic [QIW:0]       q_len,
  output logic [QIW-1:0]     q_idx,
  input  logic [IDW-1:0]     q_id,
  input  logic [XW-1:0]      q_x,
  input  logic [YW-1:0]      q_y,
  input  logic [7:0]         q_w,
  input  logic [7:0]         q_h,
  input  logic [NRES-1:0]    res_vld,
  input  logic [NRES*XW-1:0] res_x,
  input  logic [NRES*YW-1:0] res_y,
  input  logic [NOTH-1:0]    oth_vld,
  input  logic [NOTH*XW-1:0] oth_x,
  input  logic [NOTH*YW-1:0] oth_y,
  output logic               sel_done,
  output logic               cand_valid,
  output logic [QIW-1:0]     cand_qidx,
  output logic [IDW-1:0]     cand_id,
  output logic [15:0]        cand_score,
  output logic               disp_valid,
  output logic [IDW-1:0]     disp_id
);

  function automatic logic [15:0] ovl(input logic [XW-1:0] ax, input logic [YW-1:0] ay,
                                      input logic [7:0] w, input logic [7:0] h,
                                      input logic [XW-1:0] bx, input logic [YW-1:0] by);
    logic [XW-1:0] dx;
    logic [YW-1:0] dy;
    logic [7:0] a, b;
    dx = (ax > bx) ? ax - bx : bx - ax;
    dy = (ay > by) ? ay - by : by - ay;
    if (int'(dx) > int'(w) || int'(dy) > int'(h)) return 16'd0;
    a = w - 8'(dx);
    b = h - 8'(dy);
    return {8'd0, a} * {8'd0, b};
  endfunction

  logic [XW-1:0] cx;
  assign cx = q_x >> LSH;

  logic [SW-1:0] acc_h, acc_o;
  logic [15:0]   tot_h, tot_o;
  logic [CW-1:0] res_cnt;

  always_comb begin
    acc_h = '0;
    res_cnt = '0;
    for (int i = 0; i < NRES; i++) begin
      if (res_vld[i]) begin
        acc_h = acc_h + SW'(ovl(cx, q_y, q_w, q_h, res_x[i*XW +: XW] >> LSH, res_y[i*YW +: YW]));
        res_cnt = res_cnt + CW'(1);
      end
    end
    acc_o = '0;
    for (int j = 0; j < NOTH; j++)
      if (oth_vld[j])
        acc_o = acc_o + SW'(ovl(cx, q_y, q_w, q_h, oth_x[j*XW +: XW] >> LSH, oth_y[j*YW +: YW]));
  end

  assign tot_h = (acc_h > SW'(16'hFFFF)) ? 16'hFFFF : acc_h[15:0];
  assign tot_o = (acc_o > SW'(16'hFFFF)) ? 16'hFFFF : acc_o[15:0];

  logic           busy;
  logic [QIW-1:0] idx;
  logic [15:0]    best_h, best_o;
  logic [QIW-1:0] best_hi, best_oi;
  logic [IDW-1:0] best_hid, best_oid;

  logic go, eval, last, bypass, h_better, o_better;
  logic [15:0]    nb_h, nb_o;
  logic [QIW-1:0] nb_hi, nb_oi;
  logic [IDW-1:0] nb_hid, nb_oid;

  assign go     = sel_start | blk_done;
  assign eval   = go | busy;
  assign q_idx  = (busy && !go) ? idx : '0;
  assign last   = ({1'b0, q_idx} == q_len - (QIW+1)'(1));
  assign bypass = res_cnt < CW'(INIT_RES);

  assign h_better = go ? (tot_h != 16'd0) : (tot_h > best_h);
  assign o_better = go | (tot_o < best_o);
  assign nb_h   = h_better ? tot_h : (go ? 16'd0 : best_h);
  assign nb_hi  = h_better ? q_idx : best_hi;
  assign nb_hid = h_better ? q_id  : best_hid;
  assign nb_o   = o_better ? tot_o : best_o;
  assign nb_oi  = o_better ? q_idx : best_oi;
  assign nb_oid = o_better ? q_id  : best_oid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0;
      best_h <= '0; best_hi <= '0; best_hid <= '0;
      best_o <= '0; best_oi <= '0; best_oid <= '0;
      sel_done <= 1'b0; cand_valid <= 1'b0; cand_qidx <= '0; cand_id <= '0; cand_score <= '0;
      disp_valid <= 1'b0; disp_id <= '0;
    end else begin
      sel_done   <= 1'b0;
      disp_valid <= 1'b0;
      if (blk_done) begin
        disp_valid <= cand_valid;
        disp_id    <= cand_id;
      end
      if (go) cand_valid <= 1'b0;
      if (go && q_len == '0) begin
        busy <= 1'b0;
        sel_done <= 1'b1;
      end else if (go && bypass) begin
        busy <= 1'b0;
        sel_done <= 1'b1;
        cand_valid <= 1'b1; cand_qidx <= '0; cand_id <= q_id; cand_score <= '0;
      end else if (eval) begin
        best_h <= nb_h; best_hi <= nb_hi; best_hid <= nb_hid;
        best_o <= nb_o; best_oi <= nb_oi; best_oid <= nb_oid;
        if (last) begin
          busy <= 1'b0;
          sel_done <= 1'b1;
          cand_valid <= 1'b1;
          if (nb_h != 16'd0) begin
            cand_qidx <= nb_hi; cand_id <= nb_hid; cand_score <= nb_h;
          end else begin
            cand_qidx <= nb_oi; cand_id <= nb_oid; cand_score <= 16'd0;
          end
        end else begin
          busy <= 1'b1;
          idx  <= q_idx + QIW'(1);
        end
      end
    end
  end

  a_r9_empty_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (go && q_len == '0) |=> (sel_done && !cand_valid));

  a_r7_init_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (go && q_len != '0 && $countones(res_vld) < INIT_RES)
      |=> (sel_done && cand_valid && cand_qidx == '0 && cand_score == 16'd0));

  a_r8_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !go && $past(busy) && !$past(go)) |-> (q_idx == $past(q_idx) + QIW'(1)));

  a_r10_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && cand_valid) |=> (disp_valid && disp_id == $past(cand_id)));

  a_r10_no_ghost: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ($past(blk_done) && $past(cand_valid)));

endmodule

// File: tb/lblk_sel_test.sv
`timescale 1ns/1ps
module lblk_sel_test;
  localparam int NRES = 12, NOTH = 12, QDEPTH = 16, XW = 16, YW = 12, IDW = 10;
  localparam int QIW = $clog2(QDEPTH);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sel_start, blk_done;
  logic [QIW:0] q_len;
  logic [QIW-1:0] q_idx;
  logic [IDW-1:0] q_id;
  logic [XW-1:0] q_x;
  logic [YW-1:0] q_y;
  logic [7:0] q_w, q_h;
  logic [NRES-1:0] res_vld;
  logic [NRES*XW-1:0] res_x;
  logic [NRES*YW-1:0] res_y;
  logic [NOTH-1:0] oth_vld;
  logic [NOTH*XW-1:0] oth_x;
  logic [NOTH*YW-1:0] oth_y;
  logic sel_done, cand_valid, disp_valid;
  logic [QIW-1:0] cand_qidx;
  logic [IDW-1:0] cand_id, disp_id;
  logic [15:0] cand_score;

  int blen;
  logic [IDW-1:0] bq_id [QDEPTH];
  logic [XW-1:0]  bq_x  [QDEPTH];
  logic [YW-1:0]  bq_y  [QDEPTH];
  logic [7:0]     bq_w  [QDEPTH], bq_h [QDEPTH];
  logic [XW-1:0]  rx [NRES], ox [NOTH];
  logic [YW-1:0]  ry [NRES], oy [NOTH];

  assign q_len = (QIW+1)'(blen);
  assign q_id = bq_id[q_idx];
  assign q_x  = bq_x[q_idx];
  assign q_y  = bq_y[q_idx];
  assign q_w  = bq_w[q_idx];
  assign q_h  = bq_h[q_idx];
  always_comb begin
    for (int r = 0; r < NRES; r++) begin
      res_x[r*XW +: XW] = rx[r];
      res_y[r*YW +: YW] = ry[r];
    end
    for (int r = 0; r < NOTH; r++) begin
      oth_x[r*XW +: XW] = ox[r];
      oth_y[r*YW +: YW] = oy[r];
    end
  end

  lblk_sel uut (.clk(clk), .rst_n(rst_n), .sel_start(sel_start), .blk_done(blk_done),
    .q_len(q_len), .q_idx(q_idx), .q_id(q_id), .q_x(q_x), .q_y(q_y), .q_w(q_w), .q_h(q_h),
    .res_vld(res_vld), .res_x(res_x), .res_y(res_y), .oth_vld(oth_vld), .oth_x(oth_x), .oth_y(oth_y),
    .sel_done(sel_done), .cand_valid(cand_valid), .cand_qidx(cand_qidx), .cand_id(cand_id),
    .cand_score(cand_score), .disp_valid(disp_valid), .disp_id(disp_id));

  int checks = 0, errors = 0;
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model built from R1..R6
  function automatic int pair(int ax, int ay, int w, int h, int bx, int by);
    int dx, dy;
    dx = ax / 128 - bx / 128; if (dx < 0) dx = -dx;
    dy = ay - by;             if (dy < 0) dy = -dy;
    if (dx > w || dy > h) return 0;
    return (w - dx) * (h - dy);
  endfunction

  function automatic int total(int e, bit other);
    int s = 0;
    for (int r = 0; r < NRES; r++) begin
      if (!other && res_vld[r]) s += pair(bq_x[e], bq_y[e], bq_w[e], bq_h[e], rx[r], ry[r]);
      if (other && oth_vld[r])  s += pair(bq_x[e], bq_y[e], bq_w[e], bq_h[e], ox[r], oy[r]);
    end
    return (s > 65535) ? 65535 : s;
  endfunction

  // scoreboard
  int exp_v[$], exp_qi[$], exp_id[$], exp_sc[$];
  string exp_tag[$];
  int last_v = 0, last_id = 0;

  always @(negedge clk) begin
    if (rst_n && sel_done) begin
      if (exp_v.size() == 0) chk("R8 unexpected sel_done", 1, 0);
      else begin
        string t;
        int v, qi, id, sc;
        t = exp_tag.pop_front(); v = exp_v.pop_front(); qi = exp_qi.pop_front();
        id = exp_id.pop_front(); sc = exp_sc.pop_front();
        chk({t, " cand_valid"}, cand_valid, v);
        if (v != 0) begin
          chk({t, " cand_qidx"}, cand_qidx, qi);
          chk({t, " cand_id"}, cand_id, id);
          chk({t, " cand_score"}, cand_score, sc);
        end
      end
    end
  end

  task automatic run_sel(string tag, bit use_done);
    int v, qi, id, sc, cyc, n, cnt, best, bo, t;
    cnt = $countones(res_vld);
    v = (blen > 0); qi = 0; id = 0; sc = 0;
    if (blen == 0) cyc = 1;
    else if (cnt < 8) begin cyc = 1; id = bq_id[0]; end
    else begin
      cyc = blen; best = 0;
      for (int e = 0; e < blen; e++) begin
        t = total(e, 0);
        if (t > best) begin best = t; qi = e; end
      end
      if (best > 0) sc = best;
      else begin
        bo = total(0, 1); qi = 0;
        for (int e = 1; e < blen; e++) begin
          t = total(e, 1);
          if (t < bo) begin bo = t; qi = e; end
        end
      end
      id = bq_id[qi];
    end
    exp_tag.push_back(tag); exp_v.push_back(v); exp_qi.push_back(qi);
    exp_id.push_back(id); exp_sc.push_back(sc);
    if (use_done) blk_done = 1'b1; else sel_start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      sel_start = 1'b0; blk_done = 1'b0;
      n++;
      if (n == 1 && use_done) begin
        chk("R10 disp_valid", disp_valid, last_v);
        if (last_v != 0) chk("R10 disp_id", disp_id, last_id);
      end
    end while (!sel_done && n < 40);
    chk({"R8 scan length ", tag}, n, cyc);
    last_v = v; last_id = id;
    @(negedge clk);
  endtask

  task automatic clear_all();
    blen = 0; res_vld = '0; oth_vld = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      bq_id[i] = IDW'(i); bq_x[i] = '0; bq_y[i] = '0; bq_w[i] = '0; bq_h[i] = '0;
    end
    for (int r = 0; r < NRES; r++) begin rx[r] = '0; ry[r] = '0; ox[r] = '0; oy[r] = '0; end
  endtask

  task automatic put(int e, int id, int x, int y, int w, int h);
    bq_id[e] = IDW'(id); bq_x[e] = XW'(x); bq_y[e] = YW'(y); bq_w[e] = 8'(w); bq_h[e] = 8'(h);
  endtask

  task automatic far_residents();
    for (int r = 0; r < NRES; r++) begin rx[r] = XW'(128*200); ry[r] = YW'(500); end
  endtask

  initial begin
    #(4 * 200000);
    chk("watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel_start = 1'b0; blk_done = 1'b0;
    clear_all();
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 sel_done", sel_done, 0);
    chk("R11 cand_valid", cand_valid, 0);
    chk("R11 disp_valid", disp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 empty queue
    run_sel("R9", 0);
    // R10 completion with no candidate: no dispatch
    run_sel("R9", 1);

    // R7 bypass with three residents
    blen = 4; res_vld = 12'h007;
    for (int e = 0; e < 4; e++) put(e, 100 + e, 128*e, 0, 5, 5);
    run_sel("R7", 0);

    // R1 R2 R3 R5: one nearby resident, seven far away
    far_residents(); res_vld = 12'h0FF;
    rx[0] = XW'(128*10 + 77); ry[0] = 20;
    blen = 4;
    put(0, 200, 128*10, 20, 4, 4);        // 16
    put(1, 201, 128*12 + 50, 23, 10, 8);  // (10-2)*(8-3) = 40
    put(2, 202, 128*21, 20, 10, 10);      // dx 11 > 10: 0
    put(3, 203, 128*12 + 127, 23, 10, 8); // ties with entry 1
    run_sel("R5", 0);
    chk("R3 product score", cand_score, 40);
    chk("R1 line conversion and R5 tie lowest index", cand_qidx, 1);

    // R2 edge: dx equal to width gives zero
    blen = 1; put(0, 210, 128*20, 20, 10, 3);
    run_sel("R2", 0);
    chk("R2 dx==width zero", cand_score, 0);

    // R6 fallback to smallest other-SM total
    far_residents(); res_vld = 12'h0FF;
    oth_vld = 12'h001; ox[0] = XW'(128*10); oy[0] = 20;
    blen = 4;
    put(0, 300, 128*10, 20, 4, 4);
    put(1, 301, 128*12, 23, 10, 8);
    put(2, 302, 128*21, 20, 10, 10);
    put(3, 303, 128*12, 23, 10, 8);
    run_sel("R6", 0);
    chk("R6 min other index", cand_qidx, 2);

    // R10 dispatch of the held candidate, then reselection
    run_sel("R10", 1);

    // R4 invalid residents ignored: four at the entry's corner, masked off
    far_residents(); oth_vld = '0;
    for (int r = 8; r < 12; r++) begin rx[r] = XW'(128*5); ry[r] = 5; end
    res_vld = 12'h0FF;
    blen = 2; put(0, 400, 128*5, 5, 6, 6); put(1, 401, 128*5, 5, 3, 3);
    run_sel("R4 masked", 0);
    chk("R4 masked residents add nothing", cand_score, 0);

    // R4 saturation
    res_vld = 12'hFFF;
    for (int r = 0; r < NRES; r++) begin rx[r] = '0; ry[r] = '0; end
    blen = 2; put(0, 500, 0, 0, 255, 1); put(1, 501, 0, 0, 255, 255);
    run_sel("R4 saturate", 0);
    chk("R4 saturated total", cand_score, 65535);

    // random rounds against the model (R1..R10)
    for (int k = 0; k < 40; k++) begin
      blen = 1 + ($urandom % QDEPTH);
      res_vld = NRES'($urandom) | ((k % 3 != 0) ? 12'h0FF : 12'h000);
      oth_vld = NOTH'($urandom);
      for (int r = 0; r < NRES; r++) begin
        rx[r] = XW'($urandom % 4096); ry[r] = YW'($urandom % 32);
        ox[r] = XW'($urandom % 4096); oy[r] = YW'($urandom % 32);
      end
      for (int e = 0; e < QDEPTH; e++)
        put(e, 600 + e + k, $urandom % 4096, $urandom % 32, $urandom % 12, $urandom % 12);
      run_sel((k % 2 == 0) ? "R5 random" : "R10 random", bit'(k % 2));
    end

    repeat (3) @(negedge clk);
    chk("R8 scoreboard drained", exp_v.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule